// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a byte-wide path to a bank of internal control registers through one data port. A register is reached in two steps. The host first writes the register address, which lands in a 6-bit pointer. It then either writes a data byte, which goes to the register the pointer selects, or reads the port, which returns that register. A two-state machine tracks which step comes next: the pointer step (state 0) or the data step (state 1). The machine moves one step for each completed host strobe.

Two master registers live inside the block. The interrupt-control register holds a master interrupt enable and a soft-reset bit. The configuration register holds the port and counter/timer enables. Two address windows lead to the port unit and the timer unit. The block sends those units a one-cycle write pulse, an offset within the window and the data byte, and it returns their read data to the host. All other addresses are empty.

The soft-reset bit, together with the rule that a read returns the machine to state 0, gives the host a fixed six-access sequence. This sequence brings the block back to a clean state 0 no matter where it was stopped.

The host strobe, read/write select and write data pass through a parameterised synchroniser. An operation takes effect when the strobe's falling edge is seen.

The host must hold `host_we` and `host_wdata` steady for the whole time `host_stb` is high. The strobe must stay high, and then low, for at least SYNC_STAGES+1 clock cycles each. `host_rdata` is always driven with the register the pointer currently selects.

Top module: `ireg_port`

## Requirements
- R1: In state 0 a host write loads the low 6 bits of the byte into the pointer and moves to state 1. In state 1 a host write stores the byte into the selected register and returns to state 0. A write into a unit window raises `port_wr` (window base 0x10) or `timer_wr` (window base 0x20) for exactly one cycle, with `unit_addr` set to the low 4 address bits and `unit_wdata` set to the byte.
- R2: While the pointer holds an address, `host_rdata` shows that register. A host read therefore returns the contents of the address that was written just before it. Addresses 0x10–0x1F return `port_rdata`, and addresses 0x20–0x2F return `timer_rdata`.
- R3: A host read completed in either state leaves the machine in state 0. The next write is then taken as a pointer.
- R4: From any state, the host sequence read, write 0x00, read, write 0x00, write 0x01, write 0x00 leaves the block in state 0 with the soft-reset bit clear and the pointer at 0x00.
- R5: The configuration register is at address 0x01. Bits 1:0 drive `port_en`, and bits 4:2 drive `timer_en`. Writing 0x00 turns all of them off.
- R6: The interrupt-control register is at address 0x00. Bit 7 is the master interrupt enable and drives `irq_master_en`. Writing 0x00 clears it.
- R7: Bit 0 of the interrupt-control register is the soft-reset bit, and it is mirrored on `unit_rst`. While it is 1, the following hold:
  - The pointer is held at 0x00, the configuration register is held at 0x00, and `irq_master_en` is low.
  - Reads return the interrupt-control register, which reads 0x01.
  - A write with bit 0 set is ignored and produces no unit write pulse.
  - A write with bit 0 clear releases the bit and leaves the interrupt-control register at 0x00.
- R8: Addresses 0x02–0x0F and 0x30–0x3F map to no register. They read 0x00, and writes to them change nothing and pulse no unit.
- R9: A strobe held high for many clock cycles counts as a single step of the machine.
- R10: After `rst_n` the machine is in state 0 and the pointer is 0x00. Both master registers are 0x00, and `port_en`, `timer_en`, `irq_master_en` and `unit_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_stb | input | 1 | Host access strobe; an access completes when it falls |
| host_we | input | 1 | 1 = write access, 0 = read access |
| host_wdata | input | 8 | Host write byte (pointer or data) |
| host_rdata | output | 8 | Contents of the register the pointer selects |
| unit_addr | output | 4 | Offset within a unit window |
| unit_wdata | output | 8 | Data byte for a unit register write |
| port_wr | output | 1 | One-cycle write pulse to the port unit |
| timer_wr | output | 1 | One-cycle write pulse to the timer unit |
| port_rdata | input | 8 | Port unit read data at `unit_addr` |
| timer_rdata | input | 8 | Timer unit read data at `unit_addr` |
| unit_rst | output | 1 | Soft reset held to the units |
| port_en | output | 2 | Port enables from the configuration register |
| timer_en | output | 3 | Counter/timer enables from the configuration register |
| irq_master_en | output | 1 | Master interrupt enable |

## Verification
Pointer/data pairs are aimed at each master register, at both unit windows and at empty addresses. These pairs show whether the pointer step and the data step are kept apart, and whether the window decode sends each pulse to the right unit.

A read placed between a pointer and a data write shows that a read resynchronises the machine: the byte that follows acts as a pointer, not as data.

The six-access recovery sequence is started from three different places: a pending data step, an idle pointer step and an active soft reset. This shows that the sequence converges from each of them.

Strobes held for tens of cycles separate "one step per strobe" from "one step per cycle".

// File: rtl/ireg_pkg.sv
`timescale 1ns/1ps
package ireg_pkg;
  typedef enum logic {
    ST_PTR  = 1'b0,
    ST_DATA = 1'b1
  } acc_state_e;

  localparam int RST_BIT    = 0;
  localparam int IRQ_EN_BIT = 7;
endpackage

// File: rtl/ireg_strobe_sync.sv
`timescale 1ns/1ps
module ireg_strobe_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic              op_we,
  output logic [DATA_W-1:0] op_wdata
);
  logic [SYNC_STAGES-1:0] chain;
  logic stb_s, stb_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= stb;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-2:0], stb};
    end
  endgenerate

  assign stb_s = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d    <= 1'b0;
      op_we    <= 1'b0;
      op_wdata <= '0;
    end else begin
      stb_d <= stb_s;
      if (stb_s && !stb_d) begin
        op_we    <= we;
        op_wdata <= wdata;
      end
    end
  end

  // one completion per strobe, on its falling edge
  assign done = stb_d && !stb_s;

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/ireg_seq.sv
`timescale 1ns/1ps
module ireg_seq
  import ireg_pkg::*;
#(
  parameter int               PTR_W    = 6,
  parameter int               DATA_W   = 8,
  parameter logic [PTR_W-1:0] MIC_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              op_we,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              reset_mode,
  output logic [PTR_W-1:0]  ptr,
  output acc_state_e        state,
  output logic              reg_wr,
  output logic [PTR_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              rst_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_PTR;
      ptr       <= '0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rst_clr   <= 1'b0;
    end else begin
      reg_wr  <= 1'b0;
      rst_clr <= 1'b0;
      if (reset_mode) begin
        state <= ST_PTR;
        ptr   <= '0;
        if (done && op_we && !op_wdata[RST_BIT]) rst_clr <= 1'b1;
      end else if (done) begin
        if (!op_we) begin
          state <= ST_PTR;
        end else if (state == ST_PTR) begin
          ptr   <= op_wdata[PTR_W-1:0];
          state <= ST_DATA;
        end else begin
          reg_wr    <= 1'b1;
          reg_addr  <= ptr;
          reg_wdata <= op_wdata;
          state     <= ST_PTR;
          if (ptr == MIC_ADDR && op_wdata[RST_BIT]) ptr <= '0;
        end
      end
    end
  end

  AST_RST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |-> (ptr == '0 && state == ST_PTR)); // R7
  AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $past(state) == ST_DATA); // R1
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !done && !reset_mode) |=> $stable(ptr)); // R1
endmodule

// File: rtl/ireg_master.sv
`timescale 1ns/1ps
module ireg_master
  import ireg_pkg::*;
#(
  parameter int               PTR_W    = 6,
  parameter int               DATA_W   = 8,
  parameter int               N_PORT   = 2,
  parameter int               N_TIMER  = 3,
  parameter logic [PTR_W-1:0] MIC_ADDR = 6'h00,
  parameter logic [PTR_W-1:0] CFG_ADDR = 6'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [PTR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic               rst_clr,
  output logic [DATA_W-1:0]  mic,
  output logic [DATA_W-1:0]  mcc,
  output logic               reset_mode,
  output logic [N_PORT-1:0]  port_en,
  output logic [N_TIMER-1:0] timer_en,
  output logic               irq_master_en
);
  localparam int                TMR_LSB  = N_PORT;
  localparam int                TMR_MSB  = N_PORT + N_TIMER - 1;
  localparam logic [DATA_W-1:0] MIC_HOLD = DATA_W'(1) << RST_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mic <= '0;
      mcc <= '0;
    end else if (mic[RST_BIT]) begin
      mcc <= '0;
      if (rst_clr) mic <= '0;
    end else if (reg_wr) begin
      if (reg_addr == MIC_ADDR) begin
        if (reg_wdata[RST_BIT]) begin
          mic <= MIC_HOLD;
          mcc <= '0;
        end else begin
          mic <= reg_wdata;
        end
      end else if (reg_addr == CFG_ADDR) begin
        mcc <= reg_wdata;
      end
    end
  end

  assign reset_mode    = mic[RST_BIT];
  assign port_en       = mcc[N_PORT-1:0];
  assign timer_en      = mcc[TMR_MSB:TMR_LSB];
  assign irq_master_en = mic[IRQ_EN_BIT] && !mic[RST_BIT];

  AST_CFG_HELD_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |-> (mcc == '0 && mic == MIC_HOLD)); // R7
  AST_CLR_ONLY_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    rst_clr |-> reset_mode); // R7
endmodule

// File: rtl/ireg_route.sv
`timescale 1ns/1ps
module ireg_route #(
  parameter int               PTR_W      = 6,
  parameter int               DATA_W     = 8,
  parameter int               WIN_W      = 4,
  parameter logic [PTR_W-1:0] MIC_ADDR   = 6'h00,
  parameter logic [PTR_W-1:0] CFG_ADDR   = 6'h01,
  parameter logic [PTR_W-1:0] PORT_BASE  = 6'h10,
  parameter logic [PTR_W-1:0] TIMER_BASE = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [PTR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [PTR_W-1:0]  ptr,
  input  logic              reset_mode,
  input  logic [DATA_W-1:0] mic,
  input  logic [DATA_W-1:0] mcc,
  input  logic [DATA_W-1:0] port_rdata,
  input  logic [DATA_W-1:0] timer_rdata,
  output logic [WIN_W-1:0]  unit_addr,
  output logic [DATA_W-1:0] unit_wdata,
  output logic              port_wr,
  output logic              timer_wr,
  output logic [DATA_W-1:0] host_rdata
);
  localparam int               N_WIN = 2;
  localparam logic [PTR_W-1:0] WIN_BASE [N_WIN] = '{PORT_BASE, TIMER_BASE};

  logic [N_WIN-1:0] wr_hit;
  logic [N_WIN-1:0] rd_hit;

  genvar g;
  generate
    for (g = 0; g < N_WIN; g++) begin : g_win
      assign wr_hit[g] = reg_wr &&
                         (reg_addr[PTR_W-1:WIN_W] == WIN_BASE[g][PTR_W-1:WIN_W]);
      assign rd_hit[g] = (ptr[PTR_W-1:WIN_W] == WIN_BASE[g][PTR_W-1:WIN_W]);
    end
  endgenerate

  assign port_wr    = wr_hit[0];
  assign timer_wr   = wr_hit[1];
  assign unit_wdata = reg_wdata;
  assign unit_addr  = reg_wr ? reg_addr[WIN_W-1:0] : ptr[WIN_W-1:0];

  always_comb begin
    if (reset_mode)            host_rdata = mic;
    else if (ptr == MIC_ADDR)  host_rdata = mic;
    else if (ptr == CFG_ADDR)  host_rdata = mcc;
    else if (rd_hit[0])        host_rdata = port_rdata;
    else if (rd_hit[1])        host_rdata = timer_rdata;
    else                       host_rdata = '0;
  end

  AST_NO_WR_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode |-> !reg_wr); // R7
  AST_PORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> !port_wr); // R1
  AST_TIMER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timer_wr |=> !timer_wr); // R1
endmodule

// File: rtl/ireg_port.sv
`timescale 1ns/1ps
module ireg_port
  import ireg_pkg::*;
#(
  parameter int               PTR_W       = 6,
  parameter int               DATA_W      = 8,
  parameter int               WIN_W       = 4,
  parameter int               SYNC_STAGES = 2,
  parameter int               N_PORT      = 2,
  parameter int               N_TIMER     = 3,
  parameter logic [PTR_W-1:0] MIC_ADDR    = 6'h00,
  parameter logic [PTR_W-1:0] CFG_ADDR    = 6'h01,
  parameter logic [PTR_W-1:0] PORT_BASE   = 6'h10,
  parameter logic [PTR_W-1:0] TIMER_BASE  = 6'h20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_stb,
  input  logic               host_we,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [WIN_W-1:0]   unit_addr,
  output logic [DATA_W-1:0]  unit_wdata,
  output logic               port_wr,
  output logic               timer_wr,
  input  logic [DATA_W-1:0]  port_rdata,
  input  logic [DATA_W-1:0]  timer_rdata,
  output logic               unit_rst,
  output logic [N_PORT-1:0]  port_en,
  output logic [N_TIMER-1:0] timer_en,
  output logic               irq_master_en
);
  logic              done, op_we;
  logic [DATA_W-1:0] op_wdata;
  logic [PTR_W-1:0]  ptr, reg_addr;
  acc_state_e        state;
  logic              reg_wr, rst_clr, reset_mode;
  logic [DATA_W-1:0] reg_wdata, mic, mcc;

  ireg_strobe_sync #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .stb(host_stb), .we(host_we), .wdata(host_wdata),
    .done(done), .op_we(op_we), .op_wdata(op_wdata)
  );

  ireg_seq #(.PTR_W(PTR_W), .DATA_W(DATA_W), .MIC_ADDR(MIC_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .done(done), .op_we(op_we), .op_wdata(op_wdata),
    .reset_mode(reset_mode), .ptr(ptr), .state(state), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rst_clr(rst_clr)
  );

  ireg_master #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .N_PORT(N_PORT), .N_TIMER(N_TIMER),
    .MIC_ADDR(MIC_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rst_clr(rst_clr), .mic(mic), .mcc(mcc),
    .reset_mode(reset_mode), .port_en(port_en), .timer_en(timer_en),
    .irq_master_en(irq_master_en)
  );

  ireg_route #(
    .PTR_W(PTR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .MIC_ADDR(MIC_ADDR),
    .CFG_ADDR(CFG_ADDR), .PORT_BASE(PORT_BASE), .TIMER_BASE(TIMER_BASE)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ptr(ptr), .reset_mode(reset_mode), .mic(mic),
    .mcc(mcc), .port_rdata(port_rdata), .timer_rdata(timer_rdata),
    .unit_addr(unit_addr), .unit_wdata(unit_wdata), .port_wr(port_wr),
    .timer_wr(timer_wr), .host_rdata(host_rdata)
  );

  assign unit_rst = reset_mode;

  AST_STATE_HOME_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_we) |=> state == ST_PTR); // R3
endmodule

// File: tb/ireg_port_bench.sv
`timescale 1ns/1ps
module ireg_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_stb = 1'b0;
  logic       host_we = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [3:0] unit_addr;
  logic [7:0] unit_wdata;
  logic       port_wr, timer_wr;
  logic [7:0] port_rdata = 8'hA5;
  logic [7:0] timer_rdata = 8'h3C;
  logic       unit_rst;
  logic [1:0] port_en;
  logic [2:0] timer_en;
  logic       irq_master_en;

  int n_vec = 0;
  int n_bad = 0;
  int p_cnt = 0, t_cnt = 0;
  logic [3:0] p_addr = 0, t_addr = 0;
  logic [7:0] p_data = 0, t_data = 0;

  ireg_port u_ireg_port (
    .clk(clk), .rst_n(rst_n), .host_stb(host_stb), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .unit_addr(unit_addr),
    .unit_wdata(unit_wdata), .port_wr(port_wr), .timer_wr(timer_wr),
    .port_rdata(port_rdata), .timer_rdata(timer_rdata), .unit_rst(unit_rst),
    .port_en(port_en), .timer_en(timer_en), .irq_master_en(irq_master_en)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (port_wr)  begin p_cnt <= p_cnt + 1; p_addr <= unit_addr; p_data <= unit_wdata; end
    if (timer_wr) begin t_cnt <= t_cnt + 1; t_addr <= unit_addr; t_data <= unit_wdata; end
  end

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] d, input int hold = 4);
    @(negedge clk);
    host_we = 1'b1; host_wdata = d; host_stb = 1'b1;
    repeat (hold) @(negedge clk);
    host_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_rd(output logic [7:0] d, input int hold = 4);
    @(negedge clk);
    host_we = 1'b0; host_stb = 1'b1;
    repeat (hold) @(negedge clk);
    d = host_rdata;
    host_stb = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    bus_wr(a); bus_wr(d);
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
    bus_wr(a); bus_rd(d);
  endtask

  task automatic recover_seq();
    logic [7:0] d;
    bus_rd(d); bus_wr(8'h00); bus_rd(d); bus_wr(8'h00); bus_wr(8'h01); bus_wr(8'h00);
  endtask

  task automatic t_reset();
    check("R10 rdata", host_rdata, 8'h00);
    check("R10 port_en", port_en, 0);
    check("R10 timer_en", timer_en, 0);
    check("R10 irq", irq_master_en, 0);
    check("R10 unit_rst", unit_rst, 0);
    reg_write(8'h01, 8'h03);
    check("R10 first write is pointer", port_en, 2'b11);
    reg_write(8'h01, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] d;
    reg_write(8'h01, 8'h1F);
    check("R5 port_en all", port_en, 2'b11);
    check("R5 timer_en all", timer_en, 3'b111);
    reg_read(8'h01, d);
    check("R2 cfg readback", d, 8'h1F);
    reg_write(8'h01, 8'h14);
    check("R5 port_en split", port_en, 2'b00);
    check("R5 timer_en split", timer_en, 3'b101);
    reg_write(8'h01, 8'h00);
    check("R5 zero port_en", port_en, 0);
    check("R5 zero timer_en", timer_en, 0);
  endtask

  task automatic t_unit();
    logic [7:0] d;
    int p0, t0;
    p0 = p_cnt; t0 = t_cnt;
    reg_write(8'h13, 8'h5A);
    check("R1 port pulse count", p_cnt, p0 + 1);
    check("R1 port offset", p_addr, 4'h3);
    check("R1 port data", p_data, 8'h5A);
    check("R1 no timer pulse", t_cnt, t0);
    reg_write(8'h2B, 8'hC3);
    check("R1 timer pulse count", t_cnt, t0 + 1);
    check("R1 timer offset", t_addr, 4'hB);
    check("R1 timer data", t_data, 8'hC3);
    check("R1 port count held", p_cnt, p0 + 1);
    reg_read(8'h13, d);
    check("R2 port read", d, 8'hA5);
    reg_read(8'h2E, d);
    check("R2 timer read", d, 8'h3C);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    reg_write(8'h00, 8'h80);
    check("R6 irq on", irq_master_en, 1);
    reg_read(8'h00, d);
    check("R6 irq readback", d, 8'h80);
    reg_write(8'h00, 8'h00);
    check("R6 irq off", irq_master_en, 0);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    int p0, t0;
    reg_write(8'h01, 8'h03);
    p0 = p_cnt; t0 = t_cnt;
    reg_write(8'h05, 8'hFF);
    reg_write(8'h31, 8'h02);
    check("R8 no port pulse", p_cnt, p0);
    check("R8 no timer pulse", t_cnt, t0);
    reg_read(8'h05, d);
    check("R8 low hole reads 0", d, 8'h00);
    reg_read(8'h3F, d);
    check("R8 high hole reads 0", d, 8'h00);
    reg_read(8'h01, d);
    check("R8 cfg untouched", d, 8'h03);
    check("R8 irq untouched", irq_master_en, 0);
    reg_write(8'h01, 8'h00);
  endtask

  task automatic t_resync();
    logic [7:0] d;
    int t0;
    t0 = t_cnt;
    bus_wr(8'h01);
    bus_rd(d);
    bus_wr(8'h21);
    bus_wr(8'h66);
    check("R3 timer pulse after resync", t_cnt, t0 + 1);
    check("R3 timer offset", t_addr, 4'h1);
    check("R3 timer data", t_data, 8'h66);
    reg_read(8'h01, d);
    check("R3 cfg not written", d, 8'h00);
  endtask

  task automatic t_reset_bit();
    logic [7:0] d;
    int p0, t0;
    reg_write(8'h01, 8'h07);
    check("R7 cfg set before", port_en, 2'b11);
    reg_write(8'h00, 8'h81);
    check("R7 unit_rst on", unit_rst, 1);
    check("R7 port_en held off", port_en, 0);
    check("R7 timer_en held off", timer_en, 0);
    check("R7 irq off in reset", irq_master_en, 0);
    bus_rd(d);
    check("R7 read in reset", d, 8'h01);
    p0 = p_cnt; t0 = t_cnt;
    bus_wr(8'h13); bus_wr(8'h77); bus_wr(8'h81);
    check("R7 odd writes ignored", unit_rst, 1);
    check("R7 no port pulse", p_cnt, p0);
    check("R7 no timer pulse", t_cnt, t0);
    check("R7 cfg still 0", port_en, 0);
    bus_wr(8'h00);
    check("R7 released", unit_rst, 0);
    reg_read(8'h01, d);
    check("R7 cfg cleared", d, 8'h00);
    reg_read(8'h00, d);
    check("R7 mic cleared", d, 8'h00);
  endtask

  task automatic t_recover();
    bus_wr(8'h01);            // stopped in data step
    recover_seq();
    check("R4 from data step: unit_rst", unit_rst, 0);
    reg_write(8'h01, 8'h0C);
    check("R4 from data step: timer_en", timer_en, 3'b011);
    check("R4 from data step: port_en", port_en, 2'b00);
    reg_write(8'h00, 8'h01);  // stopped in soft reset
    recover_seq();
    check("R4 from reset: unit_rst", unit_rst, 0);
    reg_write(8'h01, 8'h0C);
    check("R4 from reset: timer_en", timer_en, 3'b011);
    reg_write(8'h2C, 8'h10);  // stopped in pointer step
    recover_seq();
    check("R4 from idle: unit_rst", unit_rst, 0);
    check("R4 from idle: cfg cleared", timer_en, 0);
    reg_write(8'h01, 8'h0C);
    check("R4 from idle: timer_en", timer_en, 3'b011);
    reg_write(8'h01, 8'h00);
  endtask

  task automatic t_long();
    logic [7:0] d;
    int p0;
    p0 = p_cnt;
    bus_wr(8'h14, 40);
    bus_wr(8'h99, 40);
    check("R9 one pulse per long strobe", p_cnt, p0 + 1);
    check("R9 offset", p_addr, 4'h4);
    check("R9 data", p_data, 8'h99);
    bus_wr(8'h01, 30);
    bus_rd(d, 30);
    bus_wr(8'h01, 30);
    bus_wr(8'h02, 30);
    check("R9 long read is one step", port_en, 2'b10);
    reg_write(8'h01, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_cfg();
    t_unit();
    t_irq();
    t_unmapped();
    t_resync();
    t_reset_bit();
    t_recover();
    t_long();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule